// File: doc/BRIEF.md
# Masked Chip-Select Bank Decoder

This block sits in front of a local bus memory controller and decides which programmable memory bank, and therefore which of three controller types, serves each incoming access. Eight banks are held in the block. Each bank has a base word and an option word. The base word carries a base address, a two-bit controller-type field and an enable flag. The option word carries an address mask. For a 32-bit request, only the upper 17 address bits are compared with each bank's base under that bank's mask. When several banks hit, the lowest-numbered one wins.

The decode result is registered one cycle after the request is accepted. On a hit, the block pulses a grant strobe, presents the bank index and controller type, and raises the ownership line for that controller type. Ownership stays high until the serving controller reports the end of the transaction. On a miss, the block pulses a miss line and grants nothing.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_addr` is sampled only on that edge. While a transaction is open, `req_ready` is low, so the requester must hold its request. Configuration words are written through a plain write-enable port.

Top module: `cs_bank_decoder`

## Requirements
- R1: Only request address bits [31:15] take part in the compare. Bits [14:0] never change the outcome.
- R2: The bank's mask sits in option word bits [31:15]. The compare is done on address and base both ANDed with the mask, so a cleared mask bit is a don't-care.
- R3: When several banks match, the grant names the lowest-numbered matching bank.
- R4: Base word bit 0 is the bank enable. A bank with this bit clear never matches. All banks are disabled after reset.
- R5: Base word bits [6:5] select the controller type: 0 general-purpose, 1 flash, 2 user-programmable. Value 3 is reserved, and a bank programmed with it never matches. Base word bits [31:15] hold the base address.
- R6: On a hit, the cycle after acceptance shows a one-cycle `grant_valid` pulse with the bank index and type. `owner` then shows a single bit at position type (bit0 general, bit1 flash, bit2 user), held steady together with the bank and type until done.
- R7: On a miss, the cycle after acceptance shows a one-cycle `miss` pulse, no grant and no ownership, and `req_ready` stays high.
- R8: While a transaction is open, `req_ready` is low, and configuration writes have no effect.
- R9: `xact_done` sampled high while a transaction is open clears `owner` and raises `req_ready` on the following cycle.
- R10: After reset, `owner` is zero, `grant_valid` and `miss` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_opt | input | 1 | 1 writes the option word, 0 writes the base word |
| cfg_bank | input | 3 | Bank being written |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder can take a request |
| req_addr | input | 32 | Request address |
| xact_done | input | 1 | Serving controller ends the transaction |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_bank | output | 3 | Granted bank index |
| grant_type | output | 2 | Granted controller type |
| owner | output | 3 | One-hot ownership: general, flash, user |
| miss | output | 1 | One-cycle no-match pulse |

## Verification
Some properties are checked on every cycle:
- ownership is one-hot or zero;
- a grant never coincides with a miss;
- the priority encoder never names a bank with a lower-numbered hit beside it;
- disabled or reserved-type banks never raise a hit;
- the selection stays frozen while a transaction is open;
- configuration state is unchanged across a write made while busy.

Other behaviour can only be shown by the bench's scenarios:
- that the masked compare is correct across all 17 compared bits;
- that the low address bits are ignored;
- that lowest-index priority holds over all 256 enable patterns;
- that an ignored write is truly lost once the bank is used again.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic [1:0] {
    MT_GENERAL = 2'd0,
    MT_FLASH   = 2'd1,
    MT_USER    = 2'd2,
    MT_RSVD    = 2'd3
  } mach_t;

  // Base word field positions decoded by the bank registers
  localparam int EN_BIT    = 0;
  localparam int MSEL_LSB  = 5;
  localparam int NUM_TYPES = 3;
endpackage

// File: rtl/csd_bank_regs.sv
module csd_bank_regs #(
  parameter int NB = 8,
  parameter int AW = 32,
  parameter int CW = 17,
  localparam int IW = $clog2(NB),
  localparam int LSB = AW - CW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  busy,
  input  logic                  wr_opt,
  input  logic [IW-1:0]         wr_bank,
  input  logic [AW-1:0]         wr_data,
  output logic [NB-1:0][CW-1:0] base_q,
  output logic [NB-1:0][CW-1:0] mask_q,
  output logic [NB-1:0][1:0]    msel_q,
  output logic [NB-1:0]         en_q
);
  import csd_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^{wr_data[LSB-1:MSEL_LSB+2], wr_data[MSEL_LSB-1:EN_BIT+1]};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel = wr_en && !busy && (wr_bank == IW'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[b] <= '0;
        mask_q[b] <= '0;
        msel_q[b] <= '0;
        en_q[b]   <= 1'b0;
      end else if (sel) begin
        if (wr_opt) begin
          mask_q[b] <= wr_data[AW-1:LSB];
        end else begin
          base_q[b] <= wr_data[AW-1:LSB];
          msel_q[b] <= wr_data[MSEL_LSB +: 2];
          en_q[b]   <= wr_data[EN_BIT];
        end
      end
    end
  end

  // R8: writes arriving during an open transaction leave every bank untouched
  a_r8_write_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> ($stable(base_q) && $stable(mask_q) && $stable(msel_q) && $stable(en_q)));
endmodule

// File: rtl/csd_match.sv
module csd_match #(
  parameter int NB = 8,
  parameter int AW = 32,
  parameter int CW = 17,
  localparam int LSB = AW - CW
) (
  input  logic [AW-1:0]         addr,
  input  logic [NB-1:0][CW-1:0] base,
  input  logic [NB-1:0][CW-1:0] mask,
  input  logic [NB-1:0][1:0]    msel,
  input  logic [NB-1:0]         en,
  output logic [NB-1:0]         hit
);
  import csd_pkg::*;

  logic [CW-1:0] tag;
  logic unused_lo;
  assign tag = addr[AW-1:LSB];
  assign unused_lo = ^addr[LSB-1:0];

  for (genvar b = 0; b < NB; b++) begin : g_cmp
    logic type_ok;
    assign type_ok = (msel[b] != MT_RSVD);
    assign hit[b]  = en[b] && type_ok && ((tag & mask[b]) == (base[b] & mask[b]));
  end
endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
  parameter int NB = 8,
  localparam int IW = $clog2(NB)
) (
  input  logic [NB-1:0] hit,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/csd_owner_fsm.sv
module csd_owner_fsm #(
  parameter int NB = 8,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          hit_any,
  input  logic [IW-1:0] hit_idx,
  input  logic [1:0]    hit_type,
  input  logic          done,
  output logic          busy,
  output logic          grant_valid,
  output logic          miss,
  output logic [IW-1:0] bank,
  output logic [1:0]    mtype,
  output logic [2:0]    owner
);
  import csd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      grant_valid <= 1'b0;
      miss        <= 1'b0;
      bank        <= '0;
      mtype       <= '0;
    end else begin
      grant_valid <= accept && hit_any;
      miss        <= accept && !hit_any;
      if (accept && hit_any) begin
        busy  <= 1'b1;
        bank  <= hit_idx;
        mtype <= hit_type;
      end else if (busy && done) begin
        busy <= 1'b0;
      end
    end
  end

  always_comb begin
    owner = '0;
    if (busy) begin
      case (mtype)
        MT_GENERAL: owner = 3'b001;
        MT_FLASH:   owner = 3'b010;
        MT_USER:    owner = 3'b100;
        default:    owner = 3'b000;
      endcase
    end
  end

  a_r6_owner_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));
  a_r6_grant_owns: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($countones(owner) == 1));
  a_r6_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> !grant_valid);
  a_r6_hold_selection: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(bank) && $stable(mtype) && $stable(owner)));
  a_r7_miss_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (!grant_valid && owner == 3'b000));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> (owner == 3'b000));
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder #(
  parameter int NB = 8,
  parameter int AW = 32,
  parameter int CW = 17,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_opt,
  input  logic [IW-1:0] cfg_bank,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          xact_done,
  output logic          grant_valid,
  output logic [IW-1:0] grant_bank,
  output logic [1:0]    grant_type,
  output logic [2:0]    owner,
  output logic          miss
);
  import csd_pkg::*;

  logic [NB-1:0][CW-1:0] base_q, mask_q;
  logic [NB-1:0][1:0]    msel_q;
  logic [NB-1:0]         en_q;
  logic [NB-1:0]         hit_vec;
  logic                  hit_any;
  logic [IW-1:0]         hit_idx;
  logic                  busy;
  logic                  accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  csd_bank_regs #(.NB(NB), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .busy(busy), .wr_opt(cfg_opt),
    .wr_bank(cfg_bank), .wr_data(cfg_wdata),
    .base_q(base_q), .mask_q(mask_q), .msel_q(msel_q), .en_q(en_q)
  );

  csd_match #(.NB(NB), .AW(AW), .CW(CW)) u_match (
    .addr(req_addr), .base(base_q), .mask(mask_q), .msel(msel_q), .en(en_q),
    .hit(hit_vec)
  );

  csd_prio #(.NB(NB)) u_prio (
    .hit(hit_vec), .any(hit_any), .idx(hit_idx)
  );

  csd_owner_fsm #(.NB(NB)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .hit_any(hit_any),
    .hit_idx(hit_idx), .hit_type(msel_q[hit_idx]), .done(xact_done),
    .busy(busy), .grant_valid(grant_valid), .miss(miss),
    .bank(grant_bank), .mtype(grant_type), .owner(owner)
  );

  logic [NB-1:0] rsvd_vec;
  for (genvar b = 0; b < NB; b++) begin : g_rsvd
    assign rsvd_vec[b] = (msel_q[b] == MT_RSVD);
  end

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (hit_vec[hit_idx] &&
                 ((hit_vec & ((NB'(1) << hit_idx) - NB'(1))) == '0)));
  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~en_q) == '0);
  a_r5_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & rsvd_vec) == '0);
  a_r7_ready_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> req_ready);
endmodule

// File: tb/sim_cs_bank_decoder.sv
`timescale 1ns/1ps
module sim_cs_bank_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_opt = 1'b0;
  logic [2:0]  cfg_bank = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        xact_done = 1'b0;
  logic        grant_valid, miss;
  logic [2:0]  grant_bank, owner;
  logic [1:0]  grant_type;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_base [8];
  logic [31:0] m_opt  [8];

  always #10 clk = ~clk;

  cs_bank_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opt(cfg_opt), .cfg_bank(cfg_bank),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .xact_done(xact_done), .grant_valid(grant_valid),
    .grant_bank(grant_bank), .grant_type(grant_type), .owner(owner), .miss(miss)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference decode built from the requirement text
  task automatic model(input logic [31:0] a, output bit h, output int idx, output int mt);
    h = 0; idx = 0; mt = 0;
    for (int b = 7; b >= 0; b--) begin
      if (m_base[b][0] && m_base[b][6:5] != 2'd3 &&
          (((a[31:15] ^ m_base[b][31:15]) & m_opt[b][31:15]) == 17'd0)) begin
        h = 1; idx = b; mt = int'(m_base[b][6:5]);
      end
    end
  endtask

  task automatic wr(input bit opt, input int bank, input logic [31:0] d);
    cfg_we = 1; cfg_opt = opt; cfg_bank = bank[2:0]; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    if (opt) m_opt[bank] = d; else m_base[bank] = d;
  endtask

  task automatic do_req(input logic [31:0] a, input string tag);
    bit h; int idx; int mt;
    model(a, h, idx, mt);
    req_valid = 1; req_addr = a;
    chk(req_ready == 1'b1, {tag, " R8 ready idle"}, req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    if (h) begin
      chk(grant_valid == 1'b1, {tag, " R6 grant"}, grant_valid, 1);
      chk(miss == 1'b0, {tag, " R6 no miss"}, miss, 0);
      chk(grant_bank == 3'(idx), {tag, " R3 bank"}, grant_bank, idx);
      chk(grant_type == 2'(mt), {tag, " R5 type"}, grant_type, mt);
      chk(owner == 3'(1 << mt), {tag, " R6 owner"}, owner, 1 << mt);
      chk(req_ready == 1'b0, {tag, " R8 busy"}, req_ready, 0);
      xact_done = 1;
      @(posedge clk); @(negedge clk);
      xact_done = 0;
      chk(owner == 3'b000, {tag, " R9 release"}, owner, 0);
      chk(req_ready == 1'b1, {tag, " R9 ready"}, req_ready, 1);
      chk(grant_valid == 1'b0, {tag, " R6 pulse"}, grant_valid, 0);
    end else begin
      chk(miss == 1'b1, {tag, " R7 miss"}, miss, 1);
      chk(grant_valid == 1'b0, {tag, " R7 no grant"}, grant_valid, 0);
      chk(owner == 3'b000, {tag, " R7 no owner"}, owner, 0);
      chk(req_ready == 1'b1, {tag, " R7 ready"}, req_ready, 1);
      @(posedge clk); @(negedge clk);
      chk(miss == 1'b0, {tag, " R7 pulse"}, miss, 0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [31:0] A;
    for (int b = 0; b < 8; b++) begin m_base[b] = '0; m_opt[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk(owner == 3'b000, "R10 owner", owner, 0);
    chk(grant_valid == 1'b0, "R10 grant", grant_valid, 0);
    chk(miss == 1'b0, "R10 miss", miss, 0);
    chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
    do_req(32'h1234_5678, "R4 reset all disabled");

    // R3 R4: all enable patterns, every bank matching the same region
    A = 32'hA5A5_8000;
    for (int b = 0; b < 8; b++) wr(1, b, 32'hFFFF_8000);
    for (int pat = 0; pat < 256; pat++) begin
      for (int b = 0; b < 8; b++)
        wr(0, b, {A[31:15], 8'd0, 2'(b % 3), 4'd0, 1'(pat >> b)});
      do_req(A | 32'(pat * 97), "R3 R4 enable sweep");
    end

    // R5 type field sweep on bank 0 alone
    for (int b = 1; b < 8; b++) wr(0, b, 32'h0);
    for (int t = 0; t < 4; t++) begin
      wr(0, 0, {A[31:15], 8'd0, 2'(t), 4'd0, 1'b1});
      do_req(A, "R5 type sweep");
    end

    // R1 R2 mask sweep over each compared bit
    wr(0, 0, {A[31:15], 8'd0, 2'd1, 4'd0, 1'b1});
    for (int i = 0; i < 17; i++) begin
      wr(1, 0, 32'hFFFF_8000);
      do_req(A ^ (32'h8000 << i), "R2 mask set flip");
      wr(1, 0, 32'hFFFF_8000 & ~(32'h8000 << i));
      do_req(A ^ (32'h8000 << i), "R2 mask clear flip");
    end
    wr(1, 0, 32'hFFFF_8000);
    for (int k = 0; k < 15; k++) do_req(A | (32'h1 << k) | 32'(k * 13), "R1 low bits");

    // R6 R8 hold while busy, blocked request and ignored write
    wr(0, 2, {A[31:15], 8'd0, 2'd2, 4'd0, 1'b1});
    wr(0, 0, 32'h0);
    req_valid = 1; req_addr = A;
    @(posedge clk); @(negedge clk);
    req_addr = 32'h0;
    chk(grant_valid == 1'b1 && grant_bank == 3'd2, "R6 busy grant", grant_bank, 2);
    cfg_we = 1; cfg_opt = 0; cfg_bank = 3'd2; cfg_wdata = 32'h0;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); @(negedge clk);
      chk(grant_valid == 1'b0 && miss == 1'b0, "R8 blocked request", {grant_valid, miss}, 0);
      chk(owner == 3'b100 && grant_bank == 3'd2, "R6 hold", {owner, grant_bank}, {3'b100, 3'd2});
      chk(req_ready == 1'b0, "R8 ready low", req_ready, 0);
    end
    cfg_we = 0; req_valid = 0;
    xact_done = 1;
    @(posedge clk); @(negedge clk);
    xact_done = 0;
    chk(owner == 3'b000 && req_ready == 1'b1, "R9 release after hold", {owner, req_ready}, 1);
    do_req(A, "R8 write lost");

    finish_run();
  end
endmodule